// File: doc/BRIEF.md
# Split Page Translation Cache

This block caches recent virtual-to-physical page translations for a 32-bit virtual address space. That space is split into four 1 GB regions by the top two address bits. The cache has two independent direct-mapped halves of 64 entries each. One half holds translations for the two per-process regions (program and control). The other half holds translations for the shared system region. A lookup that falls in the fourth, reserved region reports a fault and never touches either half.

A requester presents a virtual address with a valid strobe. One clock later the block returns exactly one outcome: hit, miss or fault. On a hit it also returns a 30-bit physical address, made from the cached frame number and the untouched 9-bit byte offset. On a miss, the page-table walker outside the block fetches the translation and writes it back through the refill port, choosing the half explicitly. On a context switch, the process half can be flushed on its own in one cycle while system translations stay cached. Both halves can also be flushed together.

Top module: `split_xlat_buf`

## Requirements
- R1: After reset, `rsp_valid` is 0 and every entry of both halves is invalid, so a lookup to any non-reserved address reports a miss.
- R2: `lk_va[31:30]` selects the half. A value of 00 or 01 selects the process half and 10 selects the system half. A value of 11 gives `rsp_fault`=1 with `rsp_hit`=0, `rsp_miss`=0 and `rsp_pa`=0.
- R3: Each half is direct-mapped. The index is `lk_va[14:9]` and the stored tag is `lk_va[30:15]`, so the program and control regions never alias each other. A lookup hits only when the indexed entry is valid and its tag matches.
- R4: On a hit, `rsp_pa` = {stored frame number, `lk_va[8:0]`}. On a miss or a fault, `rsp_pa` is 0.
- R5: A lookup sampled at a rising edge produces `rsp_valid`=1 in the following cycle, with exactly one of hit, miss or fault set. With no lookup, `rsp_valid` and all three flags are 0.
- R6: A refill sampled at an edge writes the entry at index `refill_vpn[5:0]` of the half named by `refill_half` (0 = process, 1 = system). The written entry has tag `refill_vpn[21:6]` and frame `refill_pfn`. A lookup in the next cycle sees the new entry. A lookup in the same cycle as the refill sees the previous contents.
- R7: A refill overwrites whatever entry already occupies its index, so the previous translation at that index then misses.
- R8: `inv_proc` clears every process-half entry in one cycle, and system-half entries keep hitting.
- R9: `inv_sys` clears every system-half entry and leaves the process half intact. Asserting both flush inputs together clears the whole cache.
- R10: A refill in the same cycle as a flush of its own half survives: the flush takes effect first, then the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_va | input | 32 | Virtual address to translate |
| refill_en | input | 1 | Write a translation this cycle |
| refill_half | input | 1 | Target half: 0 process, 1 system |
| refill_vpn | input | 22 | Virtual page key, address bits 30:9 |
| refill_pfn | input | 21 | Page frame number to store |
| inv_proc | input | 1 | Flush the process half |
| inv_sys | input | 1 | Flush the system half |
| rsp_valid | output | 1 | Response present (one cycle after lookup) |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No valid matching entry |
| rsp_fault | output | 1 | Address lies in the reserved region |
| rsp_pa | output | 30 | Physical address on a hit, else 0 |

## Verification
The bench aims at these corner cases:
- Program and control addresses that differ only in bit 30. A tag missing that bit would turn the second lookup into a false hit.
- The same index written into both halves. Shared storage would make one half overwrite the other.
- Flushes of each half on its own, and of both together. A flush reaching the wrong half would leave stale hits behind, or lose system entries on a context switch.
- A lookup in the same cycle as a refill, which must miss.
- A refill in the same cycle as a flush of its own half, which must survive the flush.

Reserved-region lookups and back-to-back streams of lookups check the fault encoding and the fixed one-cycle latency.

// File: rtl/xlat_pkg.sv
// Shared definitions for the split translation cache.
// Assumes a 32-bit virtual address whose two top bits name the region.
package xlat_pkg;

    typedef enum logic [1:0] {
        RGN_PROG = 2'b00,
        RGN_CTRL = 2'b01,
        RGN_SYS  = 2'b10,
        RGN_RSVD = 2'b11
    } region_e;

    localparam int unsigned VA_W      = 32;
    localparam int unsigned NUM_HALVES = 2;
    localparam int unsigned HALF_PROC = 0;
    localparam int unsigned HALF_SYS  = 1;

endpackage

// File: rtl/xlat_region_dec.sv
// Region decoder: maps the two region bits of a virtual address onto a
// half select and a fault flag. Purely combinational.
module xlat_region_dec
    import xlat_pkg::*;
(
    input  logic [1:0] region,
    output logic       use_sys,
    output logic       fault
);

    // Classify the region bits into process, system or reserved.
    always_comb begin
        use_sys = 1'b0;
        fault   = 1'b0;
        unique case (region_e'(region))
            RGN_PROG, RGN_CTRL: use_sys = 1'b0;
            RGN_SYS:            use_sys = 1'b1;
            RGN_RSVD:           fault   = 1'b1;
            default:            fault   = 1'b1;
        endcase
    end

endmodule

// File: rtl/xlat_half.sv
// One direct-mapped half of the translation cache.
// The read is combinational. Writes and flushes land at the clock edge.
// A flush and a write in the same cycle leave the written entry valid.
// Only the valid bits are reset; tag and frame storage holds junk until written.
module xlat_half #(
    parameter int unsigned IDX_W = 6,
    parameter int unsigned TAG_W = 16,
    parameter int unsigned PFN_W = 21,
    localparam int unsigned DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PFN_W-1:0] rd_pfn
);

    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [PFN_W-1:0] pfn_q [DEPTH];

    // Valid bits: the flush clears them all first, then a write sets its own entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (flush) valid_q <= '0;
            if (wr_en) valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and frame storage, written on refill only.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            pfn_q[wr_idx] <= wr_pfn;
        end
    end

    // Combinational read and tag compare.
    always_comb begin
        rd_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_pfn = pfn_q[rd_idx];
    end

endmodule

// File: rtl/split_xlat_buf.sv
// Split translation cache top.
// Holds a process half and a system half, each direct-mapped.
// Decodes the region of each lookup and registers a one-cycle response.
// Assumes the walker outside the block picks the refill half to match the region.
module split_xlat_buf
    import xlat_pkg::*;
#(
    parameter int unsigned IDX_W = 6,
    parameter int unsigned OFF_W = 9,
    parameter int unsigned PA_W  = 30,
    localparam int unsigned KEY_W = VA_W - 1 - OFF_W,
    localparam int unsigned TAG_W = KEY_W - IDX_W,
    localparam int unsigned PFN_W = PA_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_va,
    input  logic             refill_en,
    input  logic             refill_half,
    input  logic [KEY_W-1:0] refill_vpn,
    input  logic [PFN_W-1:0] refill_pfn,
    input  logic             inv_proc,
    input  logic             inv_sys,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_pa
);

    logic             use_sys;
    logic             fault;
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [NUM_HALVES-1:0] h_flush;
    logic [NUM_HALVES-1:0] h_wr;
    logic [NUM_HALVES-1:0] h_hit;
    logic [PFN_W-1:0] h_pfn [NUM_HALVES];
    logic             sel_hit;
    logic [PFN_W-1:0] sel_pfn;

    xlat_region_dec u_dec (
        .region  (lk_va[VA_W-1 -: 2]),
        .use_sys (use_sys),
        .fault   (fault)
    );

    // Split the lookup address into index and tag fields.
    always_comb begin
        lk_idx = lk_va[OFF_W +: IDX_W];
        lk_tag = lk_va[OFF_W + IDX_W +: TAG_W];
    end

    // Per-half flush and write enables.
    always_comb begin
        h_flush[HALF_PROC] = inv_proc;
        h_flush[HALF_SYS]  = inv_sys;
        h_wr[HALF_PROC]    = refill_en && !refill_half;
        h_wr[HALF_SYS]     = refill_en &&  refill_half;
    end

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        xlat_half #(
            .IDX_W (IDX_W),
            .TAG_W (TAG_W),
            .PFN_W (PFN_W)
        ) u_half (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (h_flush[g]),
            .wr_en  (h_wr[g]),
            .wr_idx (refill_vpn[IDX_W-1:0]),
            .wr_tag (refill_vpn[KEY_W-1:IDX_W]),
            .wr_pfn (refill_pfn),
            .rd_idx (lk_idx),
            .rd_tag (lk_tag),
            .rd_hit (h_hit[g]),
            .rd_pfn (h_pfn[g])
        );
    end

    // Pick the result of the half that owns the region.
    always_comb begin
        sel_hit = use_sys ? h_hit[HALF_SYS] : h_hit[HALF_PROC];
        sel_pfn = use_sys ? h_pfn[HALF_SYS] : h_pfn[HALF_PROC];
    end

    // Register the response one cycle after the lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_fault <= lk_valid && fault;
            rsp_hit   <= lk_valid && !fault && sel_hit;
            rsp_miss  <= lk_valid && !fault && !sel_hit;
            rsp_pa    <= (lk_valid && !fault && sel_hit) ?
                         {sel_pfn, lk_va[OFF_W-1:0]} : '0;
        end
    end

endmodule

// File: rtl/split_xlat_buf_chk.sv
// Property checker for the split translation cache, attached by bind.
// It observes ports only and keeps its own count of cycles since reset.
module split_xlat_buf_chk #(
    parameter int unsigned OFF_W = 9,
    parameter int unsigned PA_W  = 30,
    parameter int unsigned KEY_W = 22,
    parameter int unsigned PFN_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [31:0]      lk_va,
    input logic             refill_en,
    input logic             refill_half,
    input logic [KEY_W-1:0] refill_vpn,
    input logic [PFN_W-1:0] refill_pfn,
    input logic             inv_proc,
    input logic             inv_sys,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic             rsp_fault,
    input logic [PA_W-1:0]  rsp_pa
);

    logic [1:0] since_q;

    // Saturating count of cycles since reset, used to guard $past lookbacks.
    always_ff @(posedge clk) begin
        if (!rst_n) since_q <= '0;
        else if (since_q != 2'd3) since_q <= since_q + 2'd1;
    end

    p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

    p_quiet_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q >= 2'd1) |-> (rsp_valid == $past(lk_valid)));

    p_fault_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q >= 2'd1 && rsp_valid) |->
            (rsp_fault == ($past(lk_va[31:30]) == 2'b11)));

    p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q >= 2'd1 && rsp_hit) |->
            (rsp_pa[OFF_W-1:0] == $past(lk_va[OFF_W-1:0])));

    p_pa_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_pa == '0));

    p_proc_flushed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q >= 2'd2 && $past(inv_proc, 2) && !$past(refill_en, 2) &&
         !$past(refill_en) && $past(lk_valid) && !$past(lk_va[31])) |-> !rsp_hit);

    p_sys_flushed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q >= 2'd2 && $past(inv_sys, 2) && !$past(refill_en, 2) &&
         !$past(refill_en) && $past(lk_valid) && ($past(lk_va[31:30]) == 2'b10))
        |-> !rsp_hit);

    p_refill_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q >= 2'd2 && $past(refill_en, 2) && !$past(refill_en) &&
         !$past(inv_proc) && !$past(inv_sys) && $past(lk_valid) &&
         ($past(lk_va[30:OFF_W]) == $past(refill_vpn, 2)) &&
         ($past(refill_half, 2) ? ($past(lk_va[31:30]) == 2'b10) : !$past(lk_va[31])))
        |-> (rsp_hit && rsp_pa[PA_W-1:OFF_W] == $past(refill_pfn, 2)));

endmodule

bind split_xlat_buf split_xlat_buf_chk #(
    .OFF_W (OFF_W),
    .PA_W  (PA_W),
    .KEY_W (KEY_W),
    .PFN_W (PFN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_va       (lk_va),
    .refill_en   (refill_en),
    .refill_half (refill_half),
    .refill_vpn  (refill_vpn),
    .refill_pfn  (refill_pfn),
    .inv_proc    (inv_proc),
    .inv_sys     (inv_sys),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_miss    (rsp_miss),
    .rsp_fault   (rsp_fault),
    .rsp_pa      (rsp_pa)
);

// File: tb/split_xlat_buf_tb.sv
// Scoreboard bench: the driver predicts each response from a table model
// and queues it; the monitor compares what the design returns.
module split_xlat_buf_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [31:0] lk_va;
    logic        refill_en;
    logic        refill_half;
    logic [21:0] refill_vpn;
    logic [20:0] refill_pfn;
    logic        inv_proc;
    logic        inv_sys;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [29:0] rsp_pa;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic        hit;
        logic        miss;
        logic        fault;
        logic [29:0] pa;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    // Reference table contents, updated from the requirements.
    logic        m_v   [2][64];
    logic [15:0] m_tag [2][64];
    logic [20:0] m_pfn [2][64];

    split_xlat_buf u_dut (
        .clk (clk), .rst_n (rst_n),
        .lk_valid (lk_valid), .lk_va (lk_va),
        .refill_en (refill_en), .refill_half (refill_half),
        .refill_vpn (refill_vpn), .refill_pfn (refill_pfn),
        .inv_proc (inv_proc), .inv_sys (inv_sys),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_miss (rsp_miss),
        .rsp_fault (rsp_fault), .rsp_pa (rsp_pa)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mkva(input logic [1:0] rgn,
                                         input logic [20:0] vpn,
                                         input logic [8:0] off);
        return {rgn, vpn, off};
    endfunction

    function automatic exp_t predict(input logic [31:0] va, input string req);
        exp_t e;
        int h;
        int idx;
        e.req = req; e.hit = 0; e.miss = 0; e.fault = 0; e.pa = '0;
        if (va[31:30] == 2'b11) begin
            e.fault = 1;
        end else begin
            h   = va[31] ? 1 : 0;
            idx = int'(va[14:9]);
            if (m_v[h][idx] && m_tag[h][idx] == va[30:15]) begin
                e.hit = 1;
                e.pa  = {m_pfn[h][idx], va[8:0]};
            end else begin
                e.miss = 1;
            end
        end
        return e;
    endfunction

    // One cycle of stimulus; the expectation uses the table before this cycle's updates.
    task automatic step(input bit lk, input logic [31:0] va, input string req,
                        input bit rf, input bit rh, input logic [21:0] rv,
                        input logic [20:0] rp, input bit ip, input bit is_);
        @(negedge clk);
        lk_valid = lk; lk_va = lk ? va : '0;
        refill_en = rf; refill_half = rh; refill_vpn = rv; refill_pfn = rp;
        inv_proc = ip; inv_sys = is_;
        if (lk) exp_q.push_back(predict(va, req));
        for (int i = 0; i < 64; i++) begin
            if (ip) m_v[0][i] = 1'b0;
            if (is_) m_v[1][i] = 1'b0;
        end
        if (rf) begin
            m_v  [rh][int'(rv[5:0])] = 1'b1;
            m_tag[rh][int'(rv[5:0])] = rv[21:6];
            m_pfn[rh][int'(rv[5:0])] = rp;
        end
    endtask

    task automatic look(input logic [31:0] va, input string req);
        step(1, va, req, 0, 0, '0, '0, 0, 0);
    endtask

    task automatic fill(input bit h, input logic [21:0] vpn, input logic [20:0] pfn);
        step(0, '0, "", 1, h, vpn, pfn, 0, 0);
    endtask

    task automatic idle();
        step(0, '0, "", 0, 0, '0, '0, 0, 0);
    endtask

    // Monitor: sample a quarter period after the rising edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (rst_n && !done) begin
                if (rsp_valid) begin
                    n_checks++;
                    if (exp_q.size() == 0) begin
                        n_fail++;
                        $display("FAIL R5: response with none expected, act hit=%0b miss=%0b fault=%0b exp none",
                                 rsp_hit, rsp_miss, rsp_fault);
                    end else begin
                        e = exp_q.pop_front();
                        if ({rsp_hit, rsp_miss, rsp_fault} != {e.hit, e.miss, e.fault} || rsp_pa != e.pa) begin
                            n_fail++;
                            $display("FAIL %s: act h/m/f=%0b%0b%0b pa=%h exp h/m/f=%0b%0b%0b pa=%h",
                                     e.req, rsp_hit, rsp_miss, rsp_fault, rsp_pa,
                                     e.hit, e.miss, e.fault, e.pa);
                        end
                    end
                end else if (exp_q.size() != 0) begin
                    n_checks++;
                    n_fail++;
                    e = exp_q.pop_front();
                    $display("FAIL R5: missing response for %s, act rsp_valid=0 exp 1", e.req);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: act timeout exp completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; lk_valid = 0; lk_va = '0; refill_en = 0; refill_half = 0;
        refill_vpn = '0; refill_pfn = '0; inv_proc = 0; inv_sys = 0;
        for (int h = 0; h < 2; h++)
            for (int i = 0; i < 64; i++) begin
                m_v[h][i] = 0; m_tag[h][i] = '0; m_pfn[h][i] = '0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (rsp_valid || rsp_hit || rsp_miss || rsp_fault || rsp_pa != '0) begin
            n_fail++;
            $display("FAIL R1: reset outputs act v=%0b h=%0b m=%0b f=%0b pa=%h exp all zero",
                     rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_pa);
        end
        rst_n = 1'b1;

        // R1: empty after reset, every region misses
        look(mkva(2'b00, 21'h00_0000, 9'h000), "R1");
        look(mkva(2'b01, 21'h1F_FFFF, 9'h1FF), "R1");
        look(mkva(2'b10, 21'h0A_5A5A, 9'h0AA), "R1");
        // R2: reserved region faults
        look(mkva(2'b11, 21'h00_0000, 9'h000), "R2");
        look(mkva(2'b11, 21'h1F_FFFF, 9'h1FF), "R2");

        // R6: refill visible next cycle, with offset pass-through (R4)
        fill(0, {1'b0, 21'h01_2345}, 21'h1A_BCDE);
        look(mkva(2'b00, 21'h01_2345, 9'h000), "R6");
        look(mkva(2'b00, 21'h01_2345, 9'h1FF), "R4");
        look(mkva(2'b00, 21'h01_2345, 9'h0C3), "R4");

        // R6: lookup in the same cycle as its refill sees old contents
        step(1, mkva(2'b00, 21'h00_0FC7, 9'h011), "R6", 1, 0, {1'b0, 21'h00_0FC7}, 21'h05_5555, 0, 0);
        look(mkva(2'b00, 21'h00_0FC7, 9'h011), "R6");

        // R2/R3: system half, same index as the process entry
        fill(1, {1'b0, 21'h1E_2345}, 21'h0F_0F0F);
        look(mkva(2'b10, 21'h1E_2345, 9'h123), "R2");
        look(mkva(2'b00, 21'h01_2345, 9'h123), "R3");
        // R3: control region with the program-region page bits must miss
        look(mkva(2'b01, 21'h01_2345, 9'h000), "R3");
        // R2: system half must not serve a process address with the same bits
        look(mkva(2'b00, 21'h1E_2345, 9'h000), "R2");
        fill(0, {1'b1, 21'h00_1111}, 21'h12_3456);
        look(mkva(2'b01, 21'h00_1111, 9'h07F), "R3");

        // R7: conflicting refill replaces the old translation
        fill(0, {1'b0, 21'h07_3345}, 21'h00_0001);
        look(mkva(2'b00, 21'h01_2345, 9'h000), "R7");
        look(mkva(2'b00, 21'h07_3345, 9'h005), "R7");

        // R8: process flush keeps system entries
        step(0, '0, "", 0, 0, '0, '0, 1, 0);
        look(mkva(2'b00, 21'h07_3345, 9'h005), "R8");
        look(mkva(2'b01, 21'h00_1111, 9'h07F), "R8");
        look(mkva(2'b10, 21'h1E_2345, 9'h123), "R8");

        // R9: system flush keeps process entries
        fill(0, {1'b0, 21'h00_0042}, 21'h0A_0A0A);
        step(0, '0, "", 0, 0, '0, '0, 0, 1);
        look(mkva(2'b10, 21'h1E_2345, 9'h123), "R9");
        look(mkva(2'b00, 21'h00_0042, 9'h100), "R9");

        // R10: refill together with a full flush survives; others cleared (R9)
        fill(1, {1'b0, 21'h10_0003}, 21'h1F_0000);
        step(0, '0, "", 1, 1, {1'b0, 21'h10_0009}, 21'h03_3333, 1, 1);
        look(mkva(2'b10, 21'h10_0009, 9'h00F), "R10");
        look(mkva(2'b10, 21'h10_0003, 9'h00F), "R9");
        look(mkva(2'b00, 21'h00_0042, 9'h100), "R9");

        // R5: back-to-back lookups over many indexes and regions
        for (int k = 0; k < 16; k++)
            fill(k[0], {1'b0, 21'(k * 21'h41 + 21'h100)}, 21'(k * 21'h1357));
        for (int k = 0; k < 24; k++)
            look(mkva(2'(k % 4), 21'((k % 16) * 21'h41 + 21'h100), 9'(k * 7)), "R5");

        idle(); idle(); idle();
        done = 1'b1;
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R5: act %0d responses outstanding exp 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule